// File: doc/BRIEF.md
# UART Register Front End with Receive Buffer

This block is the software-facing side of a serial port. It sits on a word-addressed memory-mapped bus. Received bytes come in on a byte stream with a valid/ready handshake and are held in a receive FIFO until software reads them. A byte written to the data register leaves on a transmit byte stream as a one-cycle valid pulse. The bit-level serializer, the baud generator and DMA are outside the block. Their divisor and control registers are only stored here and read back.

The receive FIFO holds either one entry or the full parameterised depth, depending on a line-control bit. Two raw interrupt sources, receive and transmit, are masked and ORed into one registered interrupt output. Software clears the sources through a write-one-to-clear register. The last eight words of the address window return fixed identification bytes.

Top module: `uart_reg_front`

## Requirements
- R1: After reset the flag word reads 0x90, the control word reads 0x300 and the FIFO level word reads 0x12. Every other stored register reads 0, `irq` is low and `rx_ready` is high.
- R2: Writes are stored and read back at these word indices, truncated to the stated widths: 8 low-power divisor (8 bits), 9 integer divisor (16 bits), 10 fractional divisor (6 bits), 11 line control (8 bits), 12 control (16 bits), 13 FIFO level (6 bits), 14 interrupt mask (11 bits), 18 DMA control (3 bits).
- R3: Word indices 0x3F8 to 0x3FF (byte offsets 0xFE0 to 0xFFC) read, in that order, 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R4: Receive capacity is the FIFO depth (16) when line-control bit 4 is 1 and one entry when it is 0. `rx_ready` is low exactly when the FIFO is at capacity, and a byte offered while `rx_ready` is low is dropped.
- R5: The flag word at index 6 has bit 7 always 1 (transmit empty) and bit 5 always 0 (transmit full). Bit 6 (receive full) is 1 when 16 entries are held, and bit 4 (receive empty) is 1 when none are held.
- R6: A read of index 0 returns the oldest byte and removes it. On an empty FIFO the read returns the entry at the current read position and changes no state.
- R7: Raw bit 4 (receive) is set when an accepted byte makes the count 1. It is cleared when a data read leaves the count at 0.
- R8: A write to index 0 emits bits 7:0 on `tx_data` with `tx_valid` high for one cycle, and sets raw bit 5 (transmit).
- R9: A write to index 17 clears each raw bit that is written as 1 and leaves the other raw bits unchanged.
- R10: Index 15 reads the raw bits and index 16 reads raw AND mask. `irq` is high exactly when raw AND mask is nonzero.
- R11: Read data appears one cycle after the request with `bus_rvalid` high. Unmapped indices read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word index into the register window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | FIFO can accept a byte |
| tx_data | output | 8 | Transmit byte |
| tx_valid | output | 1 | Transmit byte valid, one-cycle pulse |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench builds the block with its default depth of 16 and a 16-bit bus. With these values the full flag can be reached by filling the FIFO in deep mode. Draining all 16 entries wraps the read position back onto a slot that is still known, so the value returned by an empty read can be predicted. The single-entry mode is checked by offering a second byte and showing that it is dropped.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  // Word indices of the register window
  localparam int IX_DATA  = 0;
  localparam int IX_FLAG  = 6;
  localparam int IX_LPDIV = 8;
  localparam int IX_IBAUD = 9;
  localparam int IX_FBAUD = 10;
  localparam int IX_LINE  = 11;
  localparam int IX_CTRL  = 12;
  localparam int IX_LEVEL = 13;
  localparam int IX_MASK  = 14;
  localparam int IX_RAW   = 15;
  localparam int IX_MSKD  = 16;
  localparam int IX_CLR   = 17;
  localparam int IX_DMA   = 18;

  // Interrupt source positions inside the raw / mask words
  localparam int IRQ_LSB  = 4;  // receive source bit, transmit is next
  localparam int LINE_DEEP_BIT = 4;

  localparam logic [15:0] CTRL_RST  = 16'h0300;
  localparam logic [5:0]  LEVEL_RST = 6'h12;

  function automatic logic [7:0] ident_byte(input logic [2:0] i);
    case (i)
      3'd0: ident_byte = 8'h11;
      3'd1: ident_byte = 8'h10;
      3'd2: ident_byte = 8'h14;
      3'd3: ident_byte = 8'h00;
      3'd4: ident_byte = 8'h0D;
      3'd5: ident_byte = 8'hF0;
      3'd6: ident_byte = 8'h05;
      default: ident_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/urf_id_rom.sv
module urf_id_rom (
  input  logic [2:0] idx,
  output logic [7:0] id_byte
);
  import uart_reg_pkg::*;
  always_comb id_byte = ident_byte(idx);
endmodule

// File: rtl/urf_rx_fifo.sv
module urf_rx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              deep,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count,
  output logic              pushed,
  output logic              popped
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic              at_cap;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    step = (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign at_cap   = deep ? (count == CNT_W'(DEPTH)) : (count != '0);
  assign in_ready = !at_cap;
  assign pushed   = in_valid && !at_cap;
  assign popped   = rd_en && (count != '0);

  // Storage without reset and with a registered read port
  always_ff @(posedge clk) begin
    if (pushed) mem[wp] <= in_data;
    if (rd_en)  rd_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (pushed) wp <= step(wp);
      if (popped) rp <= step(rp);
      case ({pushed, popped})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_reg_front.sv
module uart_reg_front #(
  parameter int ADDR_W     = 10,
  parameter int BUS_W      = 16,
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_valid,
  output logic              irq
);
  import uart_reg_pkg::*;

  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int PTR_W = $clog2(FIFO_DEPTH);

  logic [7:0]  lpdiv_q;
  logic [15:0] ibaud_q;
  logic [5:0]  fbaud_q;
  logic [7:0]  line_q;
  logic [15:0] ctrl_q;
  logic [5:0]  level_q;
  logic [10:0] mask_q, mask_d;
  logic [2:0]  dma_q;
  logic [1:0]  raw_q, raw_d;   // [0] receive, [1] transmit

  logic              wr_en, rd_en, rd_data_en, is_ident;
  logic [CNT_W-1:0]  rx_count;
  logic [DATA_W-1:0] fifo_q;
  logic              pushed, popped;
  logic [7:0]        id_byte;
  logic [BUS_W-1:0]  rdata_q, rd_mux;
  logic              sel_fifo_q;
  logic [7:0]        flags;

  assign wr_en      = bus_sel && bus_wr;
  assign rd_en      = bus_sel && !bus_wr;
  assign rd_data_en = rd_en && (bus_addr == ADDR_W'(IX_DATA));
  assign is_ident   = (bus_addr[ADDR_W-1:3] == '1);

  urf_rx_fifo #(
    .DATA_W(DATA_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .PTR_W(PTR_W)
  ) u_fifo (
    .clk(clk), .rst(rst), .deep(line_q[LINE_DEEP_BIT]),
    .in_valid(rx_valid), .in_data(rx_data), .in_ready(rx_ready),
    .rd_en(rd_data_en), .rd_data(fifo_q), .count(rx_count),
    .pushed(pushed), .popped(popped)
  );

  urf_id_rom u_id (.idx(bus_addr[2:0]), .id_byte(id_byte));

  assign flags = {1'b1, (rx_count == CNT_W'(FIFO_DEPTH)), 1'b0,
                  (rx_count == '0), 4'b0};

  // Interrupt and mask next state
  always_comb begin
    raw_d  = raw_q;
    mask_d = mask_q;
    if (wr_en && bus_addr == ADDR_W'(IX_CLR))
      raw_d = raw_d & ~bus_wdata[IRQ_LSB +: 2];
    if (wr_en && bus_addr == ADDR_W'(IX_MASK))
      mask_d = bus_wdata[10:0];
    if (wr_en && bus_addr == ADDR_W'(IX_DATA))
      raw_d[1] = 1'b1;
    if (pushed && !popped && rx_count == '0)
      raw_d[0] = 1'b1;
    else if (popped && !pushed && rx_count == CNT_W'(1))
      raw_d[0] = 1'b0;
  end

  // Read multiplexer
  always_comb begin
    rd_mux = '0;
    if (is_ident) rd_mux = BUS_W'(id_byte);
    else begin
      case (bus_addr)
        ADDR_W'(IX_FLAG):  rd_mux = BUS_W'(flags);
        ADDR_W'(IX_LPDIV): rd_mux = BUS_W'(lpdiv_q);
        ADDR_W'(IX_IBAUD): rd_mux = BUS_W'(ibaud_q);
        ADDR_W'(IX_FBAUD): rd_mux = BUS_W'(fbaud_q);
        ADDR_W'(IX_LINE):  rd_mux = BUS_W'(line_q);
        ADDR_W'(IX_CTRL):  rd_mux = BUS_W'(ctrl_q);
        ADDR_W'(IX_LEVEL): rd_mux = BUS_W'(level_q);
        ADDR_W'(IX_MASK):  rd_mux = BUS_W'(mask_q);
        ADDR_W'(IX_RAW):   rd_mux = BUS_W'({raw_q, 4'b0});
        ADDR_W'(IX_MSKD):  rd_mux = BUS_W'({raw_q & mask_q[IRQ_LSB +: 2], 4'b0});
        ADDR_W'(IX_DMA):   rd_mux = BUS_W'(dma_q);
        default:           rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lpdiv_q    <= '0;
      ibaud_q    <= '0;
      fbaud_q    <= '0;
      line_q     <= '0;
      ctrl_q     <= CTRL_RST;
      level_q    <= LEVEL_RST;
      mask_q     <= '0;
      dma_q      <= '0;
      raw_q      <= '0;
      irq        <= 1'b0;
      tx_data    <= '0;
      tx_valid   <= 1'b0;
      rdata_q    <= '0;
      sel_fifo_q <= 1'b0;
      bus_rvalid <= 1'b0;
    end else begin
      raw_q      <= raw_d;
      mask_q     <= mask_d;
      irq        <= |(raw_d & mask_d[IRQ_LSB +: 2]);
      tx_valid   <= wr_en && bus_addr == ADDR_W'(IX_DATA);
      bus_rvalid <= rd_en;
      if (rd_en) begin
        rdata_q    <= rd_mux;
        sel_fifo_q <= rd_data_en;
      end
      if (wr_en) begin
        case (bus_addr)
          ADDR_W'(IX_DATA):  tx_data <= bus_wdata[DATA_W-1:0];
          ADDR_W'(IX_LPDIV): lpdiv_q <= bus_wdata[7:0];
          ADDR_W'(IX_IBAUD): ibaud_q <= bus_wdata[15:0];
          ADDR_W'(IX_FBAUD): fbaud_q <= bus_wdata[5:0];
          ADDR_W'(IX_LINE):  line_q  <= bus_wdata[7:0];
          ADDR_W'(IX_CTRL):  ctrl_q  <= bus_wdata[15:0];
          ADDR_W'(IX_LEVEL): level_q <= bus_wdata[5:0];
          ADDR_W'(IX_DMA):   dma_q   <= bus_wdata[2:0];
          default: ;
        endcase
      end
    end
  end

  assign bus_rdata = sel_fifo_q ? BUS_W'(fifo_q) : rdata_q;
endmodule

// File: rtl/uart_reg_front_chk.sv
module uart_reg_front_chk #(
  parameter int ADDR_W     = 10,
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rvalid,
  input logic              tx_valid,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [CNT_W-1:0]  count,
  input logic [1:0]        raw,
  input logic              deep
);
  // R8
  tx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(bus_sel && bus_wr && bus_addr == '0));

  // R11
  rvalid_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_sel && !bus_wr));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(FIFO_DEPTH));

  // R4
  single_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (!deep && count != '0) |-> !rx_ready);

  // R7
  rx_raise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(raw[0]) |-> $past(rx_valid && rx_ready));

  // R7
  rx_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(raw[0]) |-> (count == '0 ||
                       $past(bus_sel && bus_wr && bus_addr == ADDR_W'(17))));
endmodule

bind uart_reg_front uart_reg_front_chk #(
  .ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rvalid(bus_rvalid), .tx_valid(tx_valid),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .count(rx_count),
  .raw(raw_q), .deep(line_q[4])
);

// File: tb/uart_reg_front_tb.sv
module uart_reg_front_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];
  int  model_cnt = 0;
  bit  model_deep = 0;
  logic [7:0] first_deep;

  always #4 clk = ~clk;

  uart_reg_front u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .tx_data(tx_data), .tx_valid(tx_valid), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    if (a == 10'd0) tx_q.push_back(d[7:0]);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    chk("R11 rvalid", {15'b0, bus_rvalid}, 16'h1);
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [9:0] a, input logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  // Data read: pops the scoreboard when the model holds entries
  task automatic rd_pop(input string req, input logic [7:0] exp_empty);
    logic [15:0] d;
    logic [7:0]  e;
    if (model_cnt > 0) begin e = rx_q.pop_front(); model_cnt--; end
    else e = exp_empty;
    rd(10'd0, d);
    chk(req, d, {8'h00, e});
  endtask

  task automatic push(input logic [7:0] b);
    bit exp_rdy;
    @(negedge clk);
    exp_rdy = model_deep ? (model_cnt < 16) : (model_cnt < 1);
    chk("R4 rx_ready", {15'b0, rx_ready}, {15'b0, exp_rdy});
    rx_valid = 1; rx_data = b;
    if (exp_rdy) begin rx_q.push_back(b); model_cnt++; end
    @(negedge clk);
    rx_valid = 0;
  endtask

  // Transmit monitor
  always @(negedge clk) begin
    if (!rst && tx_valid) begin
      if (tx_q.size() == 0) chk("R8 unexpected tx", {8'h0, tx_data}, 16'hFFFF);
      else chk("R8 tx byte", {8'h0, tx_data}, {8'h0, tx_q.pop_front()});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] ids [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {15'b0, irq}, 16'h0);
    chk("R1 rx_ready", {15'b0, rx_ready}, 16'h1);
    rd_chk("R1 R5 flags", 10'd6, 16'h0090);
    rd_chk("R1 control", 10'd12, 16'h0300);
    rd_chk("R1 level", 10'd13, 16'h0012);
    rd_chk("R1 mask", 10'd14, 16'h0000);
    rd_chk("R1 raw", 10'd15, 16'h0000);
    rd_chk("R1 line", 10'd11, 16'h0000);

    // R2 storage and truncation
    wr(10'd8, 16'h12A5);  rd_chk("R2 lpdiv", 10'd8, 16'h00A5);
    wr(10'd9, 16'hBCDE);  rd_chk("R2 ibaud", 10'd9, 16'hBCDE);
    wr(10'd10, 16'hFFEA); rd_chk("R2 fbaud", 10'd10, 16'h002A);
    wr(10'd12, 16'h8301); rd_chk("R2 control", 10'd12, 16'h8301);
    wr(10'd13, 16'h00FF); rd_chk("R2 level", 10'd13, 16'h003F);
    wr(10'd18, 16'hFFFF); rd_chk("R2 dma", 10'd18, 16'h0007);
    wr(10'd14, 16'hF800); rd_chk("R2 mask", 10'd14, 16'h0000);

    // R11 unmapped index
    wr(10'd3, 16'hFFFF);
    rd_chk("R11 unmapped", 10'd3, 16'h0000);
    rd_chk("R11 no side effect", 10'd8, 16'h00A5);

    // R3 identification bytes
    for (int i = 0; i < 8; i++)
      rd_chk("R3 ident", 10'h3F8 + 10'(i), {8'h00, ids[i]});

    // Single-entry mode: R4 R5 R7 R10 R6
    push(8'h5A);
    chk("R4 full single", {15'b0, rx_ready}, 16'h0);
    rd_chk("R5 not empty", 10'd6, 16'h0080);
    rd_chk("R7 raw rx set", 10'd15, 16'h0010);
    chk("R10 irq masked off", {15'b0, irq}, 16'h0);
    wr(10'd14, 16'h0010);
    chk("R10 irq on", {15'b0, irq}, 16'h1);
    rd_chk("R10 masked", 10'd16, 16'h0010);
    push(8'h77);  // dropped, R4
    rd_pop("R6 data", 8'h00);
    rd_chk("R7 raw rx cleared", 10'd15, 16'h0000);
    chk("R10 irq off", {15'b0, irq}, 16'h0);
    rd_chk("R4 R5 dropped byte", 10'd6, 16'h0090);

    // Transmit and clear: R8 R9
    wr(10'd0, 16'h01C3);
    rd_chk("R8 raw tx", 10'd15, 16'h0020);
    wr(10'd14, 16'h0030);
    chk("R10 irq tx", {15'b0, irq}, 16'h1);
    push(8'h3E);
    rd_chk("R9 both raw", 10'd15, 16'h0030);
    wr(10'd17, 16'h0010);
    rd_chk("R9 clear rx only", 10'd15, 16'h0020);
    wr(10'd17, 16'h0020);
    rd_chk("R9 clear tx", 10'd15, 16'h0000);
    chk("R9 irq low", {15'b0, irq}, 16'h0);
    rd_pop("R6 data after clear", 8'h00);
    rd_chk("R7 raw after pop", 10'd15, 16'h0000);

    // Deep mode: R4 R5 R6
    wr(10'd11, 16'h0010);
    model_deep = 1;
    for (int i = 0; i < 16; i++) push(8'(8'hA0 + 8'(i * 3)));
    first_deep = 8'hA0;
    chk("R4 full deep", {15'b0, rx_ready}, 16'h0);
    rd_chk("R5 full flag", 10'd6, 16'h00C0);
    push(8'hEE);
    rd_chk("R7 raw rx deep", 10'd15, 16'h0010);
    for (int i = 0; i < 16; i++) rd_pop("R6 deep order", 8'h00);
    rd_chk("R5 empty again", 10'd6, 16'h0090);
    rd_chk("R7 raw after drain", 10'd15, 16'h0000);
    rd_pop("R6 empty read value", first_deep);
    rd_chk("R6 empty read flags", 10'd6, 16'h0090);
    rd_chk("R6 empty read raw", 10'd15, 16'h0000);

    repeat (2) @(negedge clk);
    chk("R8 all tx seen", 16'(tx_q.size()), 16'h0);
    finish_run();
  end
endmodule